// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block steers a SCSI target through its bus phases once selection has completed. It drives BSY and the three phase lines (MSG, C/D, I/O). It gathers message-out bytes while the initiator holds ATN and reads a command of the length that a decoder reports. It then optionally hands control to a data-phase engine, sends one status byte and one message-in byte, and releases the bus. The block moves no byte itself. Each byte is given to a handshake engine through a one-cycle start pulse, and the engine answers with a one-cycle done pulse and, for inbound phases, the received byte.

The three phase lines sit in one register and change in a single clock edge. Every phase change reloads a settle timer, and no handshake or data-phase start is issued until the timer has covered the bus settle time of at least 400 ns. The timer length is derived from the clock period parameter. A received abort message ends the connection straight after message-out, with no command phase.

Top module: `scsi_phase_seq`

## Requirements
- R1: While BSY is asserted, `phase_out` = {MSG, C/D, I/O} carries only these codes: 000 data-out, 001 data-in, 010 command, 011 status, 110 message-out, 111 message-in.
- R2: The phase lines move from one listed code to the next in a single cycle. The observed sequence of {BSY, phase} values contains no intermediate code.
- R3: Neither `hs_start` nor `data_go` is raised earlier than ceil(400 ns / clock period) cycles after the cycle in which `phase_out` last changed.
- R4: If `atn_in` is high when `sel_go` is taken, message-out (110) is entered. A new byte is requested only while `atn_in` is still high, and at most 255 bytes are requested.
- R5: If any message-out byte equals 0x06, the block goes to release directly after message-out. No command phase follows and no status byte is sent.
- R6: The command phase (010) reads exactly `cmd_len` bytes. `cmd_len` is sampled when the first command byte completes, and a value of 0 reads one byte.
- R7: When `data_need` is high at the end of the command phase, data-in (001) is entered if `data_in_dir` is 1, and data-out (000) otherwise. One `data_go` pulse is issued, and status follows `data_done`. When `data_need` is low, status follows the command phase directly.
- R8: Status (011) sends `status_byte` and message-in (111) then sends `msg_byte`. Each phase makes exactly one handshake, and `hs_wdata` carries the byte while `hs_start` is high.
- R9: On release the phase lines go to 000 while BSY is still high, and BSY drops one cycle later. Whenever BSY is low, `phase_out` is 000.
- R10: `rst` or `bus_rst` puts the block into bus free (BSY low, phase 000, no start pulses) by the next cycle, from any state. A normal connection can follow.
- R11: Each received message-out or command byte is reported by one `rx_valid` pulse, with the byte on `rx_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | Synchronous bus reset; returns to bus free |
| sel_go | input | 1 | Pulse: selection done, target becomes active |
| atn_in | input | 1 | ATN level from the initiator |
| cmd_len | input | CMD_LEN_W | Command length from the decoder of the first command byte |
| data_need | input | 1 | A data phase follows the command |
| data_in_dir | input | 1 | Data phase direction, 1 = data-in |
| data_done | input | 1 | Pulse: data-phase engine finished |
| status_byte | input | 8 | Byte sent in status phase |
| msg_byte | input | 8 | Byte sent in message-in phase |
| hs_done | input | 1 | Pulse: handshake engine finished one byte |
| hs_rdata | input | 8 | Byte received by the handshake engine |
| bsy_out | output | 1 | BSY drive |
| phase_out | output | 3 | {MSG, C/D, I/O}, 1 = asserted |
| hs_start | output | 1 | Pulse: transfer one byte in the current phase |
| hs_wdata | output | 8 | Byte to send (status / message-in) |
| rx_valid | output | 1 | Pulse: a byte was received |
| rx_byte | output | 8 | Received byte |
| data_go | output | 1 | Pulse: start the data phase |

## Verification
The situation hardest to reach from the ports is the 255-byte cap on message-out. The initiator must keep ATN asserted through a long run of completed handshakes, and the block must then move to command with ATN still high. The bench derives ATN from the number of message bytes its handshake responder has served. It holds ATN high without limit in one connection and counts the bytes reported on `rx_valid`. The abort path is reached the same way: ATN falls exactly when the byte carrying 0x06 completes. A bus reset is applied in the middle of a data phase.

// File: rtl/scsi_phase_pkg.sv
package scsi_phase_pkg;

    // {MSG, C/D, I/O}, 1 = asserted
    typedef enum logic [2:0] {
        PH_DOUT = 3'b000,
        PH_DIN  = 3'b001,
        PH_CMD  = 3'b010,
        PH_STAT = 3'b011,
        PH_MOUT = 3'b110,
        PH_MIN  = 3'b111
    } bus_phase_e;

    typedef enum logic [2:0] {
        S_FREE,
        S_MOUT,
        S_CMD,
        S_DATA,
        S_STAT,
        S_MIN,
        S_REL
    } seq_state_e;

    typedef struct packed {
        logic       bsy;
        logic [2:0] ph;
    } bus_ctl_t;

    localparam logic [7:0] MSG_ABORT = 8'h06;

    function automatic int settle_cycles(input int period_ns, input int settle_ns);
        int c;
        c = (settle_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic logic phase_legal(input logic [2:0] p);
        return (p != 3'b100) && (p != 3'b101);
    endfunction

endpackage

// File: rtl/phase_settle_timer.sv
module phase_settle_timer #(
    parameter int CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic settled
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign settled = (cnt_q == '0);

    // R3
    settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !settled);

endmodule

// File: rtl/msg_abort_scan.sv
module msg_abort_scan #(
    parameter logic [7:0] ABORT_CODE = 8'h06
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       abort_seen
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seen_q <= 1'b0;
        end else if (byte_valid && (byte_in == ABORT_CODE)) begin
            seen_q <= 1'b1;
        end
    end

    assign abort_seen = seen_q;

    // R5
    abort_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_in == ABORT_CODE && !clear) |=> abort_seen);

endmodule

// File: rtl/scsi_phase_seq.sv
module scsi_phase_seq
    import scsi_phase_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SETTLE_NS     = 400,
    parameter int MSG_MAX       = 255,
    parameter int CMD_LEN_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_rst,
    input  logic                 sel_go,
    input  logic                 atn_in,
    input  logic [CMD_LEN_W-1:0] cmd_len,
    input  logic                 data_need,
    input  logic                 data_in_dir,
    input  logic                 data_done,
    input  logic [7:0]           status_byte,
    input  logic [7:0]           msg_byte,
    input  logic                 hs_done,
    input  logic [7:0]           hs_rdata,
    output logic                 bsy_out,
    output logic [2:0]           phase_out,
    output logic                 hs_start,
    output logic [7:0]           hs_wdata,
    output logic                 rx_valid,
    output logic [7:0]           rx_byte,
    output logic                 data_go
);
    localparam int SETTLE_CYC = settle_cycles(CLK_PERIOD_NS, SETTLE_NS);
    localparam int CNT_W      = $clog2(MSG_MAX + 1);
    localparam logic [CNT_W-1:0] MSG_LIM = CNT_W'(MSG_MAX);

    seq_state_e           st_q, st_d;
    bus_ctl_t             ctl_q, ctl_d;
    logic                 busy_q, busy_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic [CMD_LEN_W-1:0] len_q, len_d;
    logic                 phase_load, settled, abort_seen, scan_clear;

    assign phase_load = (ctl_d.ph != ctl_q.ph);

    phase_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .load    (phase_load),
        .settled (settled)
    );

    msg_abort_scan #(.ABORT_CODE(MSG_ABORT)) u_abort (
        .clk        (clk),
        .rst        (rst),
        .clear      (scan_clear),
        .byte_valid (rx_valid && (st_q == S_MOUT)),
        .byte_in    (hs_rdata),
        .abort_seen (abort_seen)
    );

    always_comb begin
        st_d       = st_q;
        ctl_d      = ctl_q;
        busy_d     = busy_q;
        cnt_d      = cnt_q;
        len_d      = len_q;
        hs_start   = 1'b0;
        data_go    = 1'b0;
        rx_valid   = 1'b0;
        scan_clear = 1'b0;
        case (st_q)
            S_FREE: begin
                if (sel_go) begin
                    ctl_d.bsy = 1'b1;
                    cnt_d     = '0;
                    busy_d    = 1'b0;
                    if (atn_in) begin
                        st_d       = S_MOUT;
                        ctl_d.ph   = PH_MOUT;
                        scan_clear = 1'b1;
                    end else begin
                        st_d     = S_CMD;
                        ctl_d.ph = PH_CMD;
                    end
                end
            end
            S_MOUT: begin
                if (busy_q) begin
                    if (hs_done) begin
                        busy_d   = 1'b0;
                        cnt_d    = cnt_q + CNT_W'(1);
                        rx_valid = 1'b1;
                    end
                end else if (settled) begin
                    if (atn_in && (cnt_q < MSG_LIM)) begin
                        hs_start = 1'b1;
                        busy_d   = 1'b1;
                    end else if (abort_seen) begin
                        st_d     = S_REL;
                        ctl_d.ph = PH_DOUT;
                    end else begin
                        st_d     = S_CMD;
                        ctl_d.ph = PH_CMD;
                        cnt_d    = '0;
                    end
                end
            end
            S_CMD: begin
                if (busy_q) begin
                    if (hs_done) begin
                        busy_d   = 1'b0;
                        cnt_d    = cnt_q + CNT_W'(1);
                        rx_valid = 1'b1;
                        if (cnt_q == '0) begin
                            len_d = (cmd_len == '0) ? CMD_LEN_W'(1) : cmd_len;
                        end
                    end
                end else if (settled) begin
                    if ((cnt_q == '0) || (cnt_q < CNT_W'(len_q))) begin
                        hs_start = 1'b1;
                        busy_d   = 1'b1;
                    end else if (data_need) begin
                        st_d     = S_DATA;
                        ctl_d.ph = data_in_dir ? PH_DIN : PH_DOUT;
                    end else begin
                        st_d     = S_STAT;
                        ctl_d.ph = PH_STAT;
                    end
                end
            end
            S_DATA: begin
                if (busy_q) begin
                    if (data_done) begin
                        busy_d   = 1'b0;
                        st_d     = S_STAT;
                        ctl_d.ph = PH_STAT;
                    end
                end else if (settled) begin
                    data_go = 1'b1;
                    busy_d  = 1'b1;
                end
            end
            S_STAT: begin
                if (busy_q) begin
                    if (hs_done) begin
                        busy_d   = 1'b0;
                        st_d     = S_MIN;
                        ctl_d.ph = PH_MIN;
                    end
                end else if (settled) begin
                    hs_start = 1'b1;
                    busy_d   = 1'b1;
                end
            end
            S_MIN: begin
                if (busy_q) begin
                    if (hs_done) begin
                        busy_d   = 1'b0;
                        st_d     = S_REL;
                        ctl_d.ph = PH_DOUT;
                    end
                end else if (settled) begin
                    hs_start = 1'b1;
                    busy_d   = 1'b1;
                end
            end
            S_REL: begin
                ctl_d.bsy = 1'b0;
                st_d      = S_FREE;
            end
            default: begin
                st_d  = S_FREE;
                ctl_d = '0;
            end
        endcase
        if (bus_rst) begin
            st_d     = S_FREE;
            ctl_d    = '0;
            busy_d   = 1'b0;
            hs_start = 1'b0;
            data_go  = 1'b0;
            rx_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_FREE;
            ctl_q  <= '0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
            len_q  <= CMD_LEN_W'(1);
        end else begin
            st_q   <= st_d;
            ctl_q  <= ctl_d;
            busy_q <= busy_d;
            cnt_q  <= cnt_d;
            len_q  <= len_d;
        end
    end

    always_comb begin
        case (st_q)
            S_STAT:  hs_wdata = status_byte;
            S_MIN:   hs_wdata = msg_byte;
            default: hs_wdata = 8'h00;
        endcase
    end

    assign bsy_out   = ctl_q.bsy;
    assign phase_out = ctl_q.ph;
    assign rx_byte   = hs_rdata;

    // Cycles elapsed since the phase lines last moved, saturating.
    localparam int GW = $clog2(SETTLE_CYC + 1);
    logic [2:0]    ph_prev_q;
    logic [GW-1:0] gap_q, age_now;

    assign age_now = (ctl_q.ph != ph_prev_q) ? '0 : gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_prev_q <= '0;
            gap_q     <= GW'(SETTLE_CYC);
        end else begin
            ph_prev_q <= ctl_q.ph;
            gap_q     <= (age_now == GW'(SETTLE_CYC)) ? age_now : age_now + GW'(1);
        end
    end

    // R3
    settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_start || data_go) |-> (age_now == GW'(SETTLE_CYC)));

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        bsy_out |-> phase_legal(phase_out));

    // R9
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !bsy_out |-> (phase_out == 3'b000));

    // R9
    release_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(bsy_out) && !$past(bus_rst)) |-> ($past(phase_out) == 3'b000));

    // R10
    bus_reset_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (!bsy_out && phase_out == 3'b000));

    // R5
    no_cmd_after_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_out == 3'b010 && $past(phase_out) == 3'b110) |-> !abort_seen);

endmodule

// File: tb/scsi_phase_seq_tb.sv
module scsi_phase_seq_tb;
    localparam int CLK_NS     = 10;
    localparam int SETTLE_EXP = (400 + CLK_NS - 1) / CLK_NS;
    localparam int HS_LAT     = 2;
    localparam int DATA_LAT   = 6;
    localparam int WD_CYC     = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rst = 1'b0;
    logic       sel_go = 1'b0;
    logic       atn_in;
    logic [4:0] cmd_len = '0;
    logic       data_need = 1'b0;
    logic       data_in_dir = 1'b0;
    logic       data_done = 1'b0;
    logic [7:0] status_byte = '0;
    logic [7:0] msg_byte = '0;
    logic       hs_done = 1'b0;
    logic [7:0] hs_rdata = '0;
    logic       bsy_out;
    logic [2:0] phase_out;
    logic       hs_start;
    logic [7:0] hs_wdata;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       data_go;

    always #(CLK_NS/2) clk = ~clk;

    scsi_phase_seq u_dut (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .sel_go(sel_go), .atn_in(atn_in),
        .cmd_len(cmd_len), .data_need(data_need), .data_in_dir(data_in_dir),
        .data_done(data_done), .status_byte(status_byte), .msg_byte(msg_byte),
        .hs_done(hs_done), .hs_rdata(hs_rdata), .bsy_out(bsy_out), .phase_out(phase_out),
        .hs_start(hs_start), .hs_wdata(hs_wdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .data_go(data_go)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Initiator model: ATN follows the count of message bytes served.
    bit         atn_on = 1'b0;
    int         atn_budget = 0;
    int         served_base = 0;
    int         msg_served = 0;
    logic [7:0] feed[$];
    int         rd_idx = 0;
    assign atn_in = atn_on && ((atn_budget < 0) || ((msg_served - served_base) < atn_budget));

    // Observations gathered by the monitor.
    int         msg_n = 0, cmd_n = 0, data_go_n = 0;
    logic [2:0] data_ph = '0;
    logic [7:0] rx_seen[$];
    logic [10:0] sent[$];
    logic [3:0] obs[$];
    logic [3:0] exp_seq[$];
    bit         mon_en = 1'b0;
    int b_msg, b_cmd, b_dgo, b_sent, b_rx, b_obs;

    // Handshake engine model
    initial begin
        forever begin
            @(negedge clk);
            if (hs_start) begin : serve
                logic [7:0] b;
                bit is_msg;
                b = 8'h00;
                is_msg = (phase_out == 3'b110);
                if (!phase_out[0] && rd_idx < feed.size()) begin
                    b = feed[rd_idx];
                    rd_idx++;
                end
                repeat (HS_LAT) @(posedge clk);
                #1;
                hs_done  = 1'b1;
                hs_rdata = b;
                if (is_msg) msg_served++;
                @(posedge clk);
                #1 hs_done = 1'b0;
            end
        end
    end

    // Data-phase engine model
    initial begin
        forever begin
            @(negedge clk);
            if (data_go) begin
                repeat (DATA_LAT) @(posedge clk);
                #1 data_done = 1'b1;
                @(posedge clk);
                #1 data_done = 1'b0;
            end
        end
    end

    // Per-clock reference checks
    initial begin : mon
        int since;
        logic [3:0] last;
        logic [2:0] prev_ph;
        logic prev_bsy, prev_brst;
        since = 1000; last = 4'h0; prev_ph = 3'b000; prev_bsy = 1'b0; prev_brst = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (phase_out != prev_ph) since = 0;
                else if (since < 1000000) since++;
                if (hs_start) begin
                    check(since >= SETTLE_EXP, "R3", "cycles before handshake start", since, SETTLE_EXP);
                    if (phase_out[0]) sent.push_back({phase_out, hs_wdata});
                end
                if (data_go) begin
                    check(since >= SETTLE_EXP, "R3", "cycles before data start", since, SETTLE_EXP);
                    data_go_n++;
                    data_ph = phase_out;
                end
                if (rx_valid) begin
                    if (phase_out == 3'b110) msg_n++;
                    else if (phase_out == 3'b010) cmd_n++;
                    rx_seen.push_back(rx_byte);
                end
                if (bsy_out)
                    check(phase_out != 3'b100 && phase_out != 3'b101, "R1", "phase code", int'(phase_out), 0);
                else
                    check(phase_out == 3'b000, "R9", "phase lines at bus free", int'(phase_out), 0);
                if (prev_bsy && !bsy_out && !prev_brst)
                    check(prev_ph == 3'b000, "R9", "phase before BSY release", int'(prev_ph), 0);
                if ({bsy_out, phase_out} != last) begin
                    obs.push_back({bsy_out, phase_out});
                    last = {bsy_out, phase_out};
                end
                prev_ph = phase_out; prev_bsy = bsy_out; prev_brst = bus_rst;
            end
        end
    end

    task automatic snap();
        b_msg = msg_n; b_cmd = cmd_n; b_dgo = data_go_n;
        b_sent = sent.size(); b_rx = rx_seen.size(); b_obs = obs.size();
    endtask

    task automatic run_txn(input int atn_n, input int len, input bit need, input bit din,
                           input logic [7:0] st, input logic [7:0] mg);
        int k;
        snap();
        cmd_len = 5'(len); data_need = need; data_in_dir = din;
        status_byte = st; msg_byte = mg;
        served_base = msg_served; atn_budget = atn_n; atn_on = (atn_n != 0);
        @(posedge clk); #1 sel_go = 1'b1;
        @(posedge clk); #1 sel_go = 1'b0;
        @(negedge clk);
        for (k = 0; k < 20000 && bsy_out; k++) @(negedge clk);
        check(!bsy_out, "R4", "connection finished", int'(bsy_out), 0);
        atn_on = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_seq(input string req);
        check(obs.size() - b_obs == exp_seq.size(), req, "phase step count", obs.size() - b_obs, exp_seq.size());
        for (int i = 0; i < exp_seq.size(); i++)
            if (b_obs + i < obs.size())
                check(obs[b_obs+i] == exp_seq[i], req, "phase step value", int'(obs[b_obs+i]), int'(exp_seq[i]));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(bsy_out == 1'b0, "R10", "BSY after reset", int'(bsy_out), 0);
        check(phase_out == 3'b000, "R10", "phase after reset", int'(phase_out), 0);
        check(!hs_start && !data_go, "R10", "start pulses after reset", int'(hs_start), 0);
        mon_en = 1'b1;

        // S1: plain command, data-in, status and message
        for (int i = 0; i < 6; i++) feed.push_back(8'h12 + 8'(i));
        run_txn(0, 6, 1'b1, 1'b1, 8'h02, 8'hA5);
        check(cmd_n - b_cmd == 6, "R6", "command bytes read", cmd_n - b_cmd, 6);
        check(data_go_n - b_dgo == 1, "R7", "data starts", data_go_n - b_dgo, 1);
        check(data_ph == 3'b001, "R7", "data-in code", int'(data_ph), 1);
        check(sent.size() - b_sent == 2, "R8", "bytes sent", sent.size() - b_sent, 2);
        if (sent.size() - b_sent == 2) begin
            check(sent[b_sent] == {3'b011, 8'h02}, "R8", "status phase and byte", int'(sent[b_sent]), int'({3'b011, 8'h02}));
            check(sent[b_sent+1] == {3'b111, 8'hA5}, "R8", "message-in phase and byte", int'(sent[b_sent+1]), int'({3'b111, 8'hA5}));
        end
        for (int i = 0; i < 6; i++)
            if (b_rx + i < rx_seen.size())
                check(rx_seen[b_rx+i] == 8'h12 + 8'(i), "R11", "received byte", int'(rx_seen[b_rx+i]), 8'h12 + i);
        exp_seq = '{4'hA, 4'h9, 4'hB, 4'hF, 4'h8, 4'h0};
        cmp_seq("R2");

        // S2: three message bytes, then a 10-byte command, data-out
        feed.push_back(8'h80); feed.push_back(8'h01); feed.push_back(8'h03);
        for (int i = 0; i < 10; i++) feed.push_back(8'h40 + 8'(i));
        run_txn(3, 10, 1'b1, 1'b0, 8'h00, 8'h00);
        check(msg_n - b_msg == 3, "R4", "message-out bytes", msg_n - b_msg, 3);
        check(cmd_n - b_cmd == 10, "R6", "command bytes read", cmd_n - b_cmd, 10);
        check(data_ph == 3'b000, "R7", "data-out code", int'(data_ph), 0);
        check(rx_seen.size() - b_rx == 13, "R11", "received byte count", rx_seen.size() - b_rx, 13);
        exp_seq = '{4'hE, 4'hA, 4'h8, 4'hB, 4'hF, 4'h8, 4'h0};
        cmp_seq("R2");

        // S3: abort in message-out
        feed.push_back(8'h20); feed.push_back(8'h06);
        run_txn(2, 6, 1'b1, 1'b1, 8'h02, 8'h00);
        check(msg_n - b_msg == 2, "R5", "message-out bytes before abort", msg_n - b_msg, 2);
        check(cmd_n - b_cmd == 0, "R5", "command bytes after abort", cmd_n - b_cmd, 0);
        check(sent.size() - b_sent == 0, "R5", "bytes sent after abort", sent.size() - b_sent, 0);
        exp_seq = '{4'hE, 4'h8, 4'h0};
        cmp_seq("R5");

        // S4: ATN held without limit, cap at 255 bytes
        run_txn(-1, 1, 1'b0, 1'b0, 8'h00, 8'h00);
        check(msg_n - b_msg == 255, "R4", "message-out byte cap", msg_n - b_msg, 255);
        check(cmd_n - b_cmd == 1, "R6", "command bytes after cap", cmd_n - b_cmd, 1);
        exp_seq = '{4'hE, 4'hA, 4'hB, 4'hF, 4'h8, 4'h0};
        cmp_seq("R4");

        // S5: zero command length reads one byte, no data phase
        feed.push_back(8'h00);
        run_txn(0, 0, 1'b0, 1'b0, 8'h00, 8'h00);
        check(cmd_n - b_cmd == 1, "R6", "bytes for zero length", cmd_n - b_cmd, 1);
        check(data_go_n - b_dgo == 0, "R7", "data starts without data need", data_go_n - b_dgo, 0);
        exp_seq = '{4'hA, 4'hB, 4'hF, 4'h8, 4'h0};
        cmp_seq("R2");

        // S6: bus reset in the middle of a data phase
        feed.push_back(8'h28); feed.push_back(8'h00);
        snap();
        cmd_len = 5'd2; data_need = 1'b1; data_in_dir = 1'b1;
        @(posedge clk); #1 sel_go = 1'b1;
        @(posedge clk); #1 sel_go = 1'b0;
        for (int k = 0; k < 5000 && data_go_n == b_dgo; k++) @(negedge clk);
        check(bsy_out && phase_out == 3'b001, "R10", "in data-in before bus reset", int'(phase_out), 1);
        @(posedge clk); #1 bus_rst = 1'b1;
        @(posedge clk); #1 bus_rst = 1'b0;
        @(negedge clk);
        check(!bsy_out, "R10", "BSY after bus reset", int'(bsy_out), 0);
        check(phase_out == 3'b000, "R10", "phase after bus reset", int'(phase_out), 0);
        repeat (20) @(negedge clk);

        // S7: normal connection after the bus reset
        for (int i = 0; i < 3; i++) feed.push_back(8'h60 + 8'(i));
        run_txn(0, 3, 1'b0, 1'b0, 8'h00, 8'h00);
        check(cmd_n - b_cmd == 3, "R10", "command bytes after bus reset", cmd_n - b_cmd, 3);
        exp_seq = '{4'hA, 4'hB, 4'hF, 4'h8, 4'h0};
        cmp_seq("R10");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule